// File: doc/BRIEF.md
# One-Hot Serial Pattern Recognizer

This block watches a single serial data line, taking one bit on every rising clock edge. It raises a detect flag whenever the most recent bits end in the pair 1,1 or in the triple 1,0,1. Matches may overlap: a bit that completes one match can also begin or continue the next.

The state register is strictly one-hot, with one flip-flop per state. Each flip-flop's next value is an OR of AND terms, one term per incoming transition. The reset state flop loads 1 on reset and every other flop loads 0. Reset enters only through the flop's reset branch, never through a next-state term.

An elaboration parameter picks one of two forms, and only the flops of the chosen form are built:
- **Moore form (five states).** The flag is a pure function of state, so it appears in the cycle after the completing bit has been clocked in.
- **Mealy form (three states).** The flag is combinational from the current state and the live input, so it appears in the same cycle as the completing bit.

A separate output reports whether exactly one state bit is set.

Top module: `ohpr_detector`

## Requirements
- R1: While `rst_n` is low at a rising edge, the machine returns to its idle state. After that edge, `detect` is 0 in the Moore form, and in the Mealy form even with `din` = 1.
- R2: `state_valid` is 1 exactly when one state flop holds 1. It is 1 in every cycle after reset is released.
- R3: Moore form (`MOORE` = 1): after the edge that clocks in a 1 whose preceding clocked-in bit was also 1, `detect` is 1 for that cycle.
- R4: Moore form: after the edge that clocks in the third bit of 1,0,1, `detect` is 1 for that cycle. After any edge that completes neither pattern, `detect` is 0.
- R5: Overlapping matches are all flagged. From idle, the stream 1,1,1 flags on its second and third bits. The stream 1,0,1,1 flags on its third and fourth bits.
- R6: Moore form: `detect` depends only on state. Changing `din` between clock edges leaves `detect` unchanged.
- R7: Mealy form (`MOORE` = 0): `detect` is 1 in the same cycle that `din` = 1 completes 1,1 or 1,0,1 with the previously clocked-in bits.
- R8: Mealy form: `detect` is 0 whenever `din` = 0, and whenever the presented 1 completes neither pattern.
- R9: Reset discards all history. A lone 1 after reset is not flagged, whatever bits came before the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; `din` is sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset to the idle state |
| din | input | 1 | Serial data bit |
| detect | output | 1 | Pattern flag (registered-state in Moore form, combinational in Mealy form) |
| state_valid | output | 1 | High when exactly one state flop is set |

## Verification
The bench sweeps every 8-bit stream from reset through a Moore and a Mealy instance side by side, then runs a long random stream. Expected flags come from a three-bit history of clocked-in bits.

- A design that forgets to overlap would miss the second flag of 1,1,1. A design that returns to the wrong state after a match would miss the fourth flag of 1,0,1,1.
- A Moore output wired to the live input would change when `din` is toggled mid-cycle. A Mealy form with the wrong latency would flag one bit late.
- A reset that leaves history behind would flag the lone 1 that follows a reset issued after a 1. A broken reset preset would leave `state_valid` low.

// File: rtl/ohpr_pkg.sv
// Package: shared state indices and helpers for the one-hot pattern recognizer.
// Assumes: index 0 is always the idle (reset) state in both machine forms.
package ohpr_pkg;

    // Moore form state positions
    localparam int M_IDLE  = 0;
    localparam int M_ONE   = 1;
    localparam int M_ONEZ  = 2;
    localparam int M_TWO1  = 3;
    localparam int M_ONEZ1 = 4;
    localparam int M_NUM   = 5;

    // Mealy form state positions
    localparam int Y_IDLE = 0;
    localparam int Y_ONE  = 1;
    localparam int Y_ONEZ = 2;
    localparam int Y_NUM  = 3;

    // Widest state vector of either form
    localparam int MAX_NUM = M_NUM;

    // Returns 1 when exactly one bit of the vector is set
    function automatic logic exactly_one(input logic [MAX_NUM-1:0] v);
        int n;
        n = 0;
        for (int i = 0; i < MAX_NUM; i++) begin
            n += int'(v[i]);
        end
        return (n == 1);
    endfunction

endpackage

// File: rtl/ohpr_state_flop.sv
// Module: one state flip-flop of a one-hot machine.
// Loads RST_VAL while rst_n is low at a rising edge, otherwise loads d.
// Assumes: reset is synchronous and active-low; d carries no reset term.
module ohpr_state_flop #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    // State storage with preset/clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end

endmodule

// File: rtl/ohpr_moore_core.sv
// Module: five-state Moore recognizer for 1,1 and 1,0,1 with overlap.
// Each next-state bit is the OR of its incoming transition terms.
// detect is an OR of state bits only.
// Assumes: idle is index 0 and is the only flop preset on reset.
module ohpr_moore_core
    import ohpr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    output logic             detect,
    output logic [M_NUM-1:0] state
);

    logic [M_NUM-1:0] nxt;

    // Per-flop next-state terms, one AND per incoming arc
    always_comb begin
        nxt          = '0;
        nxt[M_IDLE]  = (state[M_IDLE] & ~din) | (state[M_ONEZ] & ~din);
        nxt[M_ONE]   = state[M_IDLE] & din;
        nxt[M_ONEZ]  = (state[M_ONE] & ~din) | (state[M_TWO1] & ~din)
                     | (state[M_ONEZ1] & ~din);
        nxt[M_TWO1]  = (state[M_ONE] & din) | (state[M_TWO1] & din)
                     | (state[M_ONEZ1] & din);
        nxt[M_ONEZ1] = state[M_ONEZ] & din;
    end

    // One flip-flop per state; only idle is preset
    for (genvar i = 0; i < M_NUM; i++) begin : g_flop
        ohpr_state_flop #(.RST_VAL(i == M_IDLE)) u_flop (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (nxt[i]),
            .q     (state[i])
        );
    end

    // Output from the two accepting states
    always_comb detect = state[M_TWO1] | state[M_ONEZ1];

endmodule

// File: rtl/ohpr_mealy_core.sv
// Module: three-state Mealy recognizer for 1,1 and 1,0,1 with overlap.
// detect is combinational from the current state and the live input.
// Assumes: idle is index 0 and is the only flop preset on reset.
module ohpr_mealy_core
    import ohpr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    output logic             detect,
    output logic [Y_NUM-1:0] state
);

    logic [Y_NUM-1:0] nxt;

    // Per-flop next-state terms, one AND per incoming arc
    always_comb begin
        nxt         = '0;
        nxt[Y_IDLE] = (state[Y_IDLE] & ~din) | (state[Y_ONEZ] & ~din);
        nxt[Y_ONE]  = (state[Y_IDLE] & din) | (state[Y_ONE] & din)
                    | (state[Y_ONEZ] & din);
        nxt[Y_ONEZ] = state[Y_ONE] & ~din;
    end

    // One flip-flop per state; only idle is preset
    for (genvar i = 0; i < Y_NUM; i++) begin : g_flop
        ohpr_state_flop #(.RST_VAL(i == Y_IDLE)) u_flop (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (nxt[i]),
            .q     (state[i])
        );
    end

    // Output from the arcs that complete a pattern
    always_comb detect = (state[Y_ONE] & din) | (state[Y_ONEZ] & din);

endmodule

// File: rtl/ohpr_detector.sv
// Module: top of the one-hot pattern recognizer.
// MOORE=1 builds the five-state Moore core; MOORE=0 builds the three-state
// Mealy core. Only the chosen core is elaborated.
// Assumes: rst_n is synchronous to clk.
module ohpr_detector
    import ohpr_pkg::*;
#(
    parameter bit MOORE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic detect,
    output logic state_valid
);

    logic [MAX_NUM-1:0] state_all;

    if (MOORE) begin : g_moore
        logic [M_NUM-1:0] st;
        ohpr_moore_core u_core (
            .clk    (clk),
            .rst_n  (rst_n),
            .din    (din),
            .detect (detect),
            .state  (st)
        );
        // Widen to the common vector
        always_comb state_all = MAX_NUM'(st);
    end else begin : g_mealy
        logic [Y_NUM-1:0] st;
        ohpr_mealy_core u_core (
            .clk    (clk),
            .rst_n  (rst_n),
            .din    (din),
            .detect (detect),
            .state  (st)
        );
        // Widen to the common vector
        always_comb state_all = MAX_NUM'(st);
    end

    // Report a legal one-hot state
    always_comb state_valid = exactly_one(state_all);

endmodule

// File: rtl/ohpr_detector_chk.sv
// Module: assertion checker for ohpr_detector, attached by bind.
// Assumes: the same MOORE value as the bound instance.
module ohpr_detector_chk #(
    parameter bit MOORE = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic din,
    input logic detect,
    input logic state_valid
);

    // R2: one-hot holds whenever out of reset
    assert_one_hot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> state_valid);

    if (MOORE) begin : g_m
        // R1: first cycle after reset shows no flag
        assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> !detect);
        // R3: a second consecutive 1 flags next cycle
        assert_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (din && $past(din) && $past(rst_n)) |=> detect);
        // R4: 1,0,1 flags next cycle
        assert_triple_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (din && !$past(din) && $past(din, 2) && $past(rst_n) && $past(rst_n, 2))
            |=> detect);
        // R6: a flag needs the last consumed bit to be 1
        assert_state_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (detect && $past(rst_n)) |-> $past(din));
    end else begin : g_y
        // R8: no flag while the input is 0
        assert_zero_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !din |-> !detect);
        // R7: a 1 after a consumed 1 flags in the same cycle
        assert_pair_now_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (din && $past(din) && $past(rst_n)) |-> detect);
        // R1: first cycle after reset shows no flag
        assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> !detect);
    end

endmodule

bind ohpr_detector ohpr_detector_chk #(.MOORE(MOORE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .din         (din),
    .detect      (detect),
    .state_valid (state_valid)
);

// File: tb/ohpr_detector_bench.sv
`timescale 1ns/1ps
module ohpr_detector_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic det_m, val_m, det_y, val_y;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    logic [2:0] hist = 3'b000;   // hist[0] = most recent clocked-in bit
    string tag_over = "";

    always #2.5 clk = ~clk;

    ohpr_detector #(.MOORE(1'b1)) u_ohpr_detector (
        .clk(clk), .rst_n(rst_n), .din(din), .detect(det_m), .state_valid(val_m));

    ohpr_detector #(.MOORE(1'b0)) u_ohpr_detector_mealy (
        .clk(clk), .rst_n(rst_n), .din(din), .detect(det_y), .state_valid(val_y));

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic moore_exp(input logic [2:0] h);
        return (h[0] & h[1]) | (h[0] & ~h[1] & h[2]);
    endfunction

    // Called at a negedge: checks state, drives bit b, checks Mealy, clocks it in
    task automatic put_bit(input logic b);
        logic em, ey;
        string tm, ty;
        em = moore_exp(hist);
        tm = (hist[0] & hist[1]) ? "R3" : "R4";
        check(tag_over != "" ? tag_over : tm, det_m, em);
        check("R2", val_m, 1'b1);
        check("R2", val_y, 1'b1);
        din = b;
        #1;
        check("R6", det_m, em);
        ey = b & (hist[0] | (hist[1] & ~hist[0]));
        ty = b ? "R7" : "R8";
        check(tag_over != "" ? tag_over : ty, det_y, ey);
        @(posedge clk);
        hist = {hist[1:0], b};
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        din = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", det_m, 1'b0);
        check("R1", det_y, 1'b0);
        rst_n = 1'b1;
        hist = 3'b000;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // Exhaustive 8-bit streams from reset
        for (int s = 0; s < 256; s++) begin
            do_reset();
            for (int k = 7; k >= 0; k--) put_bit(s[k]);
            put_bit(1'b0);
        end
        // R5: overlap directed cases
        tag_over = "R5";
        do_reset();
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
        do_reset();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
        // R9: reset after a 1, then a lone 1 is not flagged
        tag_over = "R9";
        do_reset();
        put_bit(1'b1);
        do_reset();
        put_bit(1'b1);
        put_bit(1'b0);
        tag_over = "";
        // Long random stream
        do_reset();
        for (int k = 0; k < 3000; k++) put_bit(1'($urandom));
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule